// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the output side of a four-channel 24-bit audio converter running as clock master. From a master-clock enable it makes a bit clock and a frame clock. On each frame boundary it takes the most recently captured set of four samples and shifts them out, MSB first in two's complement, on one or two serial data lines. Data and the frame clock change only on falling bit-clock edges, so a receiver samples on rising edges.

There are three frame layouts. In stereo-pair mode each of the two lines carries a left/right pair in a 64-bit frame, and the frame clock has a 50% duty cycle. In the two time-division modes, with 128-bit and 256-bit frames, all four channels go out on the first line, the second line stays low, and the frame clock is a 32-bit-wide pulse. Each layout comes in two framings: left-justified, with an active-high frame clock and the MSB on the frame-clock edge, or I2S, with the frame clock inverted and the MSB one bit later. The configuration pins are only read while power-down is asserted.

Top module: `aud_ser_tx`

## Requirements
- R1: While `pdn_n` is low, `bclk` is high and `fclk`, `sd0` and `sd1` are low.
- R2: `bclk` toggles on every cycle with `mclk_en` high and holds otherwise, so one bit period is two enable ticks. `sd0`, `sd1` and `fclk` change only in the cycle in which `bclk` falls.
- R3: The frame length in bit periods is set by `fmt_sel`: 2'b00 and 2'b11 give a 64-bit stereo-pair frame, 2'b01 a 128-bit frame and 2'b10 a 256-bit frame. The first falling edge after reset starts frame bit 0.
- R4: In stereo-pair mode the frame clock is active for frame bits 0..31 (left) and inactive for bits 32..63 (right).
- R5: In both time-division modes the frame clock is active for frame bits 0..31 only.
- R6: Each channel fills a 32-bit slot: sample bit 23 first, down to bit 0, then 8 zero bits.
- R7: In stereo-pair mode `sd0` carries channel 0 in slot 0 and channel 1 in slot 1, and `sd1` carries channel 2 in slot 0 and channel 3 in slot 1.
- R8: In the time-division modes slot n of `sd0` carries channel n for n = 0..3. In the 256-bit frame slots 4..7 are all zero.
- R9: With a time-division mode selected, `sd1` stays low.
- R10: `i2s_sel` = 1 selects I2S: the frame clock is inverted (active = low) and the slot data on the lines is delayed by one bit period (frame bit 0 is zero). `i2s_sel` = 0 selects left-justified: active = high and slot bit 0 appears at frame bit 0.
- R11: A frame carries the samples of the last `smp_vld` strobe that came before the cycle of its first falling edge. A strobe in that same cycle is held for the next frame.
- R12: Changes on `fmt_sel` and `i2s_sel` while `pdn_n` is high have no effect until the next power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_n | input | 1 | Active-low power-down and reset; configuration is captured while low |
| mclk_en | input | 1 | Master-clock enable; each high cycle is one half bit period |
| fmt_sel | input | 2 | Frame layout: 00/11 stereo pair, 01 128-bit TDM, 10 256-bit TDM |
| i2s_sel | input | 1 | 1 = I2S framing, 0 = left-justified |
| smp_vld | input | 1 | Capture strobe for the four sample inputs |
| smp_ch0 | input | SMP_W | Channel 0 sample, two's complement |
| smp_ch1 | input | SMP_W | Channel 1 sample |
| smp_ch2 | input | SMP_W | Channel 2 sample |
| smp_ch3 | input | SMP_W | Channel 3 sample |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sd0 | output | 1 | First serial data line |
| sd1 | output | 1 | Second serial data line |

## Verification
Sample capture and the frame-boundary load of the shift register can fall in the same clock cycle: a new strobe arrives exactly when the first falling edge of a frame moves the held samples into the frame register. The bench tracks falling edges from the ports, times a strobe to land on that edge, and checks that the frame then starting still carries the older samples, while the next frame carries the new ones. A second strobe is placed mid-frame to show that a frame already running is not disturbed.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

   typedef enum logic [1:0] {
      FMT_PAIR     = 2'b00,
      FMT_TDM4     = 2'b01,
      FMT_TDM8     = 2'b10,
      FMT_PAIR_ALT = 2'b11
   } fmt_e;

   typedef struct packed {
      fmt_e fmt;
      logic i2s;
   } cfg_t;

   function automatic logic fmt_is_tdm(fmt_e f);
      return (f == FMT_TDM4) || (f == FMT_TDM8);
   endfunction

   // number of 32-bit slots in one frame for a layout
   function automatic int fmt_slots(fmt_e f);
      case (f)
         FMT_TDM4: return 4;
         FMT_TDM8: return 8;
         default:  return 2;
      endcase
   endfunction

endpackage

// File: rtl/aud_ser_cfg.sv
module aud_ser_cfg
   import aud_ser_pkg::*;
#(
   parameter int SLOT_W  = 32,
   parameter int PULSE_W = 32,
   parameter int CNT_W   = 8
) (
   input  logic             clk,
   input  logic             pdn_n,
   input  logic [1:0]       fmt_pins,
   input  logic             i2s_pin,
   output logic             tdm_o,
   output logic             i2s_o,
   output logic [CNT_W-1:0] frm_last_o,
   output logic [CNT_W-1:0] act_len_o
);

   cfg_t cfg_q;

   // configuration follows the pins only while powered down
   always_ff @(posedge clk) begin
      if (!pdn_n) begin
         cfg_q <= '{fmt: fmt_e'(fmt_pins), i2s: i2s_pin};
      end
   end

   assign tdm_o      = fmt_is_tdm(cfg_q.fmt);
   assign i2s_o      = cfg_q.i2s;
   assign frm_last_o = CNT_W'(fmt_slots(cfg_q.fmt) * SLOT_W - 1);
   assign act_len_o  = tdm_o ? CNT_W'(PULSE_W) : CNT_W'(SLOT_W);

   // R12: configuration frozen while running
   p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!pdn_n)
      $past(pdn_n) |-> $stable(cfg_q));

endmodule

// File: rtl/aud_ser_clkgen.sv
module aud_ser_clkgen #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             pdn_n,
   input  logic             mclk_en,
   input  logic [CNT_W-1:0] frm_last,
   output logic             bclk_o,
   output logic             fall_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] nxt_o
);

   logic             bclk_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   // reset value all-ones is past every frame end, so the first fall wraps to bit 0
   assign cnt_nxt = (cnt_q >= frm_last) ? '0 : cnt_q + 1'b1;
   assign fall_o  = mclk_en & bclk_q;

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         bclk_q <= 1'b1;
         cnt_q  <= '1;
      end else if (mclk_en) begin
         bclk_q <= ~bclk_q;
         if (bclk_q) begin
            cnt_q <= cnt_nxt;
         end
      end
   end

   assign bclk_o = bclk_q;
   assign cnt_o  = cnt_q;
   assign nxt_o  = cnt_nxt;

   // R2: one bit-clock edge per enable tick
   p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (!pdn_n)
      mclk_en |=> (bclk_q != $past(bclk_q)));

   // R2: no edge without an enable tick
   p_bclk_hold_r2: assert property (@(posedge clk) disable iff (!pdn_n)
      !mclk_en |=> $stable(bclk_q));

   // R3: frame counter wraps at the configured length
   p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!pdn_n)
      (fall_o && cnt_q == frm_last) |=> (cnt_q == '0));

endmodule

// File: rtl/aud_ser_slotmux.sv
module aud_ser_slotmux #(
   parameter int LINE   = 0,
   parameter int SMP_W  = 24,
   parameter int SLOT_W = 32,
   parameter int NCH    = 4,
   parameter int CNT_W  = 8
) (
   input  logic [NCH-1:0][SMP_W-1:0] src_i,
   input  logic [CNT_W-1:0]          pos_i,
   input  logic                      pos_ok_i,
   input  logic                      tdm_i,
   output logic                      bit_o
);

   localparam int SLOT_IW = $clog2(SLOT_W);
   localparam int SEL_W   = CNT_W - SLOT_IW;

   logic [SEL_W-1:0]   slot;
   logic [SLOT_IW-1:0] kbit;
   logic [SEL_W-1:0]   chsel;
   logic               live;
   logic [SMP_W-1:0]   word;
   logic               pick;

   assign slot = pos_i[CNT_W-1:SLOT_IW];
   assign kbit = pos_i[SLOT_IW-1:0];

   generate
      if (LINE == 0) begin : g_first
         // time-division: slot n is channel n; pair mode: channels 0 and 1
         assign chsel = slot;
         assign live  = tdm_i ? (int'(slot) < NCH) : (int'(slot) < NCH / 2);
      end else begin : g_second
         // second line only carries the upper pair, never in time-division
         assign chsel = slot + SEL_W'(NCH / 2);
         assign live  = !tdm_i && (int'(slot) < NCH / 2);
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int c = 0; c < NCH; c++) begin
         if (int'(chsel) == c) word = src_i[c];
      end
      pick = 1'b0;
      for (int i = 0; i < SMP_W; i++) begin
         if (int'(kbit) == i) pick = word[SMP_W-1-i];
      end
      bit_o = live & pos_ok_i & pick;
   end

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
   import aud_ser_pkg::*;
#(
   parameter int SMP_W   = 24,
   parameter int SLOT_W  = 32,
   parameter int NCH     = 4,
   parameter int PULSE_W = 32,
   parameter int MAX_SLT = 8
) (
   input  logic             clk,
   input  logic             pdn_n,
   input  logic             mclk_en,
   input  logic [1:0]       fmt_sel,
   input  logic             i2s_sel,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp_ch0,
   input  logic [SMP_W-1:0] smp_ch1,
   input  logic [SMP_W-1:0] smp_ch2,
   input  logic [SMP_W-1:0] smp_ch3,
   output logic             bclk,
   output logic             fclk,
   output logic             sd0,
   output logic             sd1
);

   localparam int FRM_MAX = MAX_SLT * SLOT_W;
   localparam int CNT_W   = $clog2(FRM_MAX);
   localparam int NLINE   = 2;

   generate
      if (SMP_W > SLOT_W) begin : g_chk_w
         $error("sample wider than its slot");
      end
      if (NCH != 4) begin : g_chk_n
         $error("layout needs four channels");
      end
      if ((1 << $clog2(SLOT_W)) != SLOT_W) begin : g_chk_s
         $error("slot width must be a power of two");
      end
      if (PULSE_W < 1 || PULSE_W >= 4 * SLOT_W) begin : g_chk_p
         $error("frame pulse must be shorter than the shortest TDM frame");
      end
      if (MAX_SLT != 8) begin : g_chk_m
         $error("longest frame has eight slots");
      end
   endgenerate

   logic                      tdm;
   logic                      i2s;
   logic [CNT_W-1:0]          frm_last;
   logic [CNT_W-1:0]          act_len;
   logic                      bclk_w;
   logic                      fall;
   logic [CNT_W-1:0]          cnt;
   logic [CNT_W-1:0]          nxt;
   logic [CNT_W-1:0]          pos;
   logic                      pos_ok;
   logic                      fclk_nxt;
   logic                      frm_start;
   logic [NCH-1:0][SMP_W-1:0] smp_in;
   logic [NCH-1:0][SMP_W-1:0] hold_q;
   logic [NCH-1:0][SMP_W-1:0] frm_q;
   logic [NCH-1:0][SMP_W-1:0] src;
   logic [NLINE-1:0]          line_bit;
   logic [NLINE-1:0]          sd_q;
   logic                      fclk_q;

   aud_ser_cfg #(
      .SLOT_W (SLOT_W),
      .PULSE_W(PULSE_W),
      .CNT_W  (CNT_W)
   ) u_cfg (
      .clk       (clk),
      .pdn_n     (pdn_n),
      .fmt_pins  (fmt_sel),
      .i2s_pin   (i2s_sel),
      .tdm_o     (tdm),
      .i2s_o     (i2s),
      .frm_last_o(frm_last),
      .act_len_o (act_len)
   );

   aud_ser_clkgen #(
      .CNT_W(CNT_W)
   ) u_clk (
      .clk     (clk),
      .pdn_n   (pdn_n),
      .mclk_en (mclk_en),
      .frm_last(frm_last),
      .bclk_o  (bclk_w),
      .fall_o  (fall),
      .cnt_o   (cnt),
      .nxt_o   (nxt)
   );

   assign smp_in    = {smp_ch3, smp_ch2, smp_ch1, smp_ch0};
   assign frm_start = (nxt == '0);

   // the bit leaving at frame start comes straight from the held set
   assign src    = frm_start ? hold_q : frm_q;
   assign pos    = nxt - {{(CNT_W-1){1'b0}}, i2s};
   assign pos_ok = !(i2s && frm_start);

   assign fclk_nxt = (nxt < act_len) ^ i2s;

   generate
      for (genvar ln = 0; ln < NLINE; ln++) begin : g_line
         aud_ser_slotmux #(
            .LINE  (ln),
            .SMP_W (SMP_W),
            .SLOT_W(SLOT_W),
            .NCH   (NCH),
            .CNT_W (CNT_W)
         ) u_mux (
            .src_i   (src),
            .pos_i   (pos),
            .pos_ok_i(pos_ok),
            .tdm_i   (tdm),
            .bit_o   (line_bit[ln])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         hold_q <= '0;
         frm_q  <= '0;
         fclk_q <= 1'b0;
         sd_q   <= '0;
      end else begin
         if (smp_vld) begin
            hold_q <= smp_in;
         end
         if (fall) begin
            fclk_q <= fclk_nxt;
            sd_q   <= line_bit;
            if (frm_start) begin
               frm_q <= hold_q;
            end
         end
      end
   end

   assign bclk = bclk_w;
   assign fclk = fclk_q;
   assign sd0  = sd_q[0];
   assign sd1  = sd_q[1];

   // R9: second line quiet in time-division modes
   p_sd1_low_r9: assert property (@(posedge clk) disable iff (!pdn_n)
      tdm |=> !sd_q[1]);

   // R2: data lines move only with a falling bit clock
   p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!pdn_n)
      !$stable(sd_q) |-> $fell(bclk_w));

   // R2: frame clock moves only with a falling bit clock
   p_fclk_on_fall_r2: assert property (@(posedge clk) disable iff (!pdn_n)
      !$stable(fclk_q) |-> $fell(bclk_w));

   // R4, R5: frame clock edges only at frame start or end of active span
   p_fclk_edge_pos_r5: assert property (@(posedge clk) disable iff (!pdn_n)
      !$stable(fclk_q) |-> (cnt == '0 || cnt == act_len));

endmodule

// File: tb/aud_ser_tx_tb_top.sv
module aud_ser_tx_tb_top;

   logic        clk = 1'b0;
   logic        pdn_n = 1'b0;
   logic        mclk_en = 1'b0;
   logic [1:0]  fmt_sel = 2'b00;
   logic        i2s_sel = 1'b0;
   logic        smp_vld = 1'b0;
   logic [23:0] smp_ch0 = '0, smp_ch1 = '0, smp_ch2 = '0, smp_ch3 = '0;
   logic        bclk, fclk, sd0, sd1;

   always #2 clk = ~clk;

   aud_ser_tx dut_i (
      .clk(clk), .pdn_n(pdn_n), .mclk_en(mclk_en), .fmt_sel(fmt_sel),
      .i2s_sel(i2s_sel), .smp_vld(smp_vld), .smp_ch0(smp_ch0),
      .smp_ch1(smp_ch1), .smp_ch2(smp_ch2), .smp_ch3(smp_ch3),
      .bclk(bclk), .fclk(fclk), .sd0(sd0), .sd1(sd1)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int nfall = 0;
   int ticks = 0;
   int nlen = 64;
   logic mon_on = 1'b0;
   logic gap_on = 1'b0;
   logic cur_tdm = 1'b0;
   logic cur_i2s = 1'b0;
   logic prev_b = 1'b1;
   logic last_sd0 = 1'b0, last_sd1 = 1'b0, last_fclk = 1'b0;
   logic [95:0] exp_frm [4];

   // vector: {fmt[1:0], i2s, gap, ch0, ch1, ch2, ch3}
   localparam int NVEC = 7;
   localparam logic [99:0] VEC [NVEC] = '{
      {2'b00, 1'b0, 1'b0, 24'h9A5C31, 24'h123456, 24'hFEDCBA, 24'h800001},
      {2'b00, 1'b1, 1'b1, 24'h7FFFFF, 24'h000001, 24'hC0FFEE, 24'h5A5A5A},
      {2'b01, 1'b0, 1'b0, 24'hA1B2C3, 24'h3C4D5E, 24'hF00F0F, 24'h0F1E2D},
      {2'b01, 1'b1, 1'b0, 24'h800000, 24'hFFFFFF, 24'h135791, 24'hACE024},
      {2'b10, 1'b0, 1'b0, 24'h6B2D99, 24'hD4E5F6, 24'h010203, 24'hFF00FF},
      {2'b10, 1'b1, 1'b1, 24'h2468AC, 24'hE1E2E3, 24'h55AA55, 24'h987654},
      {2'b11, 1'b0, 1'b0, 24'hFFFFFE, 24'h8ABCDE, 24'h000000, 24'h7654FE}
   };

   function automatic int len_of(logic [1:0] f);
      return (f == 2'b01) ? 128 : (f == 2'b10) ? 256 : 64;
   endfunction

   // expected line bit from R6, R7, R8, R10
   function automatic logic exp_sd(int line, int b, logic tdm, logic i2s,
                                   logic [95:0] d);
      int p, slot, k, ch;
      p = b - (i2s ? 1 : 0);
      if (p < 0) return 1'b0;
      slot = p / 32;
      k = p % 32;
      if (k >= 24) return 1'b0;
      if (tdm) begin
         if (line == 1 || slot >= 4) return 1'b0;
         ch = slot;
      end else begin
         ch = line * 2 + slot;
      end
      return d[95 - 24 * ch - k];
   endfunction

   // expected frame clock from R3, R4, R5, R10
   function automatic logic exp_fc(int b, logic i2s);
      return (b < 32) ^ i2s;
   endfunction

   task automatic chk(input logic got, input logic want, input string tag);
      total++;
      if (got !== want) begin
         bad++;
         $display("FAIL %s fall=%0d got=%b exp=%b", tag, nfall, got, want);
      end
   endtask

   // monitor and enable generator in one process
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (mon_on) begin
            if (mclk_en) ticks++;
            if (prev_b && !bclk) begin
               int b, fr;
               nfall++;
               b = (nfall - 1) % nlen;
               fr = (nfall - 1) / nlen;
               if (fr > 3) fr = 3;
               if (nfall > 1) chk(ticks == 2, 1'b1, "R2 ticks per bit");
               ticks = 0;
               chk(sd0, exp_sd(0, b, cur_tdm, cur_i2s, exp_frm[fr]),
                   cur_tdm ? "R6 R8 R10 R11 sd0" : "R6 R7 R10 R11 sd0");
               chk(sd1, exp_sd(1, b, cur_tdm, cur_i2s, exp_frm[fr]),
                   cur_tdm ? "R9 sd1" : "R7 R10 sd1");
               chk(fclk, exp_fc(b, cur_i2s),
                   cur_tdm ? "R3 R5 R10 fclk" : "R3 R4 R10 fclk");
            end else if (nfall > 0) begin
               chk(sd0 == last_sd0 && sd1 == last_sd1 && fclk == last_fclk,
                   1'b1, "R2 hold between falls");
            end
            prev_b = bclk;
            last_sd0 = sd0;
            last_sd1 = sd1;
            last_fclk = fclk;
            mclk_en <= gap_on ? (cyc % 3 == 0) : 1'b1;
         end else begin
            mclk_en <= 1'b0;
         end
      end
   end

   task automatic start(input logic [1:0] f, input logic i, input logic g,
                        input logic [95:0] d);
      mon_on = 1'b0;
      smp_vld = 1'b0;
      pdn_n = 1'b0;
      fmt_sel = f;
      i2s_sel = i;
      repeat (3) @(negedge clk);
      chk(bclk, 1'b1, "R1 bclk in power-down");
      chk(fclk | sd0 | sd1, 1'b0, "R1 fclk/sd in power-down");
      pdn_n = 1'b1;
      @(negedge clk);
      {smp_ch0, smp_ch1, smp_ch2, smp_ch3} = d;
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      cur_tdm = (f == 2'b01) || (f == 2'b10);
      cur_i2s = i;
      nlen = len_of(f);
      for (int k = 0; k < 4; k++) exp_frm[k] = d;
      gap_on = g;
      nfall = 0;
      ticks = 0;
      prev_b = 1'b1;
      mon_on = 1'b1;
   endtask

   task automatic run_frames(input int n);
      wait (nfall == n * nlen);
      @(negedge clk);
      mon_on = 1'b0;
   endtask

   task automatic strobe(input logic [95:0] d);
      @(negedge clk);
      {smp_ch0, smp_ch1, smp_ch2, smp_ch3} = d;
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   initial begin
      logic [95:0] da, db, dc;
      // table walk: every layout and framing
      for (int v = 0; v < NVEC; v++) begin
         start(VEC[v][99:98], VEC[v][97], VEC[v][96], VEC[v][95:0]);
         run_frames(2);
      end

      // R11: strobe mid-frame, then a strobe on the frame-start cycle
      da = 96'hABCDEF_123456_654321_FEDCBA;
      db = 96'h111111_888888_F0F0F0_0A0B0C;
      dc = 96'h7E7E7E_813579_246801_C3C3C3;
      start(2'b00, 1'b0, 1'b0, da);
      exp_frm[1] = db;
      exp_frm[2] = db;
      exp_frm[3] = dc;
      wait (nfall == 20);
      strobe(db);
      wait (nfall == 128);
      strobe(dc);
      run_frames(4);

      // R12: pins changed while running are ignored
      start(2'b00, 1'b0, 1'b0, db);
      wait (nfall == 10);
      fmt_sel = 2'b10;
      i2s_sel = 1'b1;
      run_frames(3);
      // R12: same pins take effect after a power-down
      start(2'b10, 1'b1, 1'b0, dc);
      run_frames(1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule